// File: doc/BRIEF.md
# Sync Header Block Lock Controller

This block decides whether a receiver is aligned to the 66-bit frame boundary. It looks only at the 2-bit sync header that comes with each frame. While it searches, it counts frames with a good header. When alignment is judged lost, it asks an external shifter to move the boundary by one bit. It also keeps a time-windowed count of bad headers. From that count it derives a high-error-rate flag. The flag withdraws sync-done without forcing realignment, and sync-done returns once the link is clean again.

The frame input is a stream with a valid strobe and no ready. The block takes one header in every cycle where the strobe is high, so it never applies back-pressure. Cycles with the strobe low carry no frame and change no frame count. The slip handshake and the status outputs are plain control pins. The barrel shifter itself and any descrambling are not part of this block.

Top module: `blk_lock_ctrl`

## Requirements
- R1: A header of 01 or 10 is good. A header of 00 or 11 is bad. Only cycles with `frm_vld` high count as frames, so a bad header with `frm_vld` low has no effect.
- R2: During reset and after it, `lock_state` is 0 (HUNT), `sync_done` is 0 and `slip_req` is 0. The state codes are HUNT=0, LOCKED=1, NOISY=2 and SLIPPING=3.
- R3: In HUNT, the 64th good frame in a row moves the state to LOCKED at the clock edge that samples that frame. A run of 63 good frames does not.
- R4: Frame windows are 64 frames long. They start at reset and again when HUNT is entered. The 32nd bad frame inside one window moves LOCKED, NOISY or HUNT to SLIPPING at the edge that samples it. With 31 bad frames, this move does not happen.
- R5: Time windows are `BER_WIN_CYC` cycles long, counted from reset. The high-error flag rises the cycle after the 16th bad frame of a window. It falls only at the end of a window that saw fewer than 16 bad frames.
- R6: LOCKED moves to NOISY while the flag is high. NOISY moves back to LOCKED once the flag is low. If the unlock condition and the flag both hold in the same cycle, the unlock condition wins.
- R7: In NOISY, `sync_done` is 0 and no slip is requested.
- R8: `slip_req` is a one-cycle pulse in the first cycle of SLIPPING. The state then stays in SLIPPING until `slip_done` is high, and then moves to HUNT. Frames seen during SLIPPING are not counted.
- R9: `sync_done` is 1 exactly when `lock_state` is LOCKED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | A frame header is present this cycle |
| frm_hdr | input | 2 | Sync header of the frame |
| slip_done | input | 1 | The shifter has finished one bit slip |
| slip_req | output | 1 | One-cycle request for a bit slip |
| sync_done | output | 1 | Frame alignment is held |
| lock_state | output | 2 | Current state code |

## Verification
Two functions can land in the same cycle: acquiring lock on the 64th good frame, and the high-error flag, which is already high from bad headers sent earlier in the same time window. The bench sends 20 bad headers, then a 64-frame good run, all inside the first time window. It then requires one cycle of LOCKED with `sync_done` high, followed by NOISY. It also requires the return to LOCKED exactly one cycle after the second time window closes without errors. A scoreboard queue holds the expected order of state changes. A monitor checks each change against that queue, and checks the slip pulse and `sync_done` at the same moment.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_LOCK  = 2'd1,
    ST_NOISY = 2'd2,
    ST_SLIP  = 2'd3
  } lk_state_e;

  function automatic logic hdr_good(input logic [1:0] h);
    return h[1] ^ h[0];
  endfunction

endpackage

// File: rtl/hdr_window.sv
module hdr_window #(
  parameter int LOCK_RUN   = 64,
  parameter int WIN_FRAMES = 64,
  parameter int UNLOCK_BAD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fv,
  input  logic good,
  output logic lock_hit,
  output logic unlock_hit
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int FW = $clog2(WIN_FRAMES);
  localparam int BW = $clog2(WIN_FRAMES + 1);

  logic [RW-1:0] run_q;
  logic [FW-1:0] frm_q;
  logic [BW-1:0] bad_q;
  logic          win_end;

  assign win_end = (frm_q == FW'(WIN_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run_q <= '0;
    end else if (fv) begin
      if (!good)                       run_q <= '0;
      else if (run_q != RW'(LOCK_RUN)) run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      frm_q <= '0;
      bad_q <= '0;
    end else if (fv) begin
      if (win_end) begin
        frm_q <= '0;
        bad_q <= '0;
      end else begin
        frm_q <= frm_q + 1'b1;
        bad_q <= bad_q + BW'(!good);
      end
    end
  end

  assign lock_hit   = fv && good && !clr && (run_q == RW'(LOCK_RUN - 1));
  assign unlock_hit = fv && !good && !clr && (bad_q == BW'(UNLOCK_BAD - 1));

  AST_BAD_WITHIN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bad_q) <= int'(frm_q)); // R4
  AST_RUN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (run_q == '0) && (frm_q == '0)); // R8
endmodule

// File: rtl/ber_monitor.sv
module ber_monitor #(
  parameter int WIN_CYC = 256,
  parameter int BAD_TH  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fv,
  input  logic good,
  output logic hi_ber
);
  localparam int TW = $clog2(WIN_CYC);
  localparam int EW = $clog2(BAD_TH + 1);

  logic [TW-1:0] tick_q;
  logic [EW-1:0] err_q;
  logic [EW:0]   err_nxt;
  logic          hit;

  assign err_nxt = {1'b0, err_q} + (EW+1)'(fv && !good);
  assign hit     = (err_nxt >= (EW+1)'(BAD_TH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      err_q  <= '0;
      hi_ber <= 1'b0;
    end else if (tick_q == TW'(WIN_CYC - 1)) begin
      tick_q <= '0;
      err_q  <= '0;
      hi_ber <= hit;
    end else begin
      tick_q <= tick_q + 1'b1;
      err_q  <= hit ? EW'(BAD_TH) : err_nxt[EW-1:0];
      if (hit) hi_ber <= 1'b1;
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tick_q) < WIN_CYC); // R5
  AST_FLAG_FALLS_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_ber) |-> ($past(tick_q) == TW'(WIN_CYC - 1))); // R5
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lock_hit,
  input  logic      unlock_hit,
  input  logic      hi_ber,
  input  logic      slip_done,
  output lk_state_e st_q,
  output logic      slip_req,
  output logic      clr
);
  lk_state_e nxt;

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      ST_HUNT:  if (unlock_hit) nxt = ST_SLIP;
                else if (lock_hit) nxt = ST_LOCK;
      ST_LOCK:  if (unlock_hit) nxt = ST_SLIP;
                else if (hi_ber) nxt = ST_NOISY;
      ST_NOISY: if (unlock_hit) nxt = ST_SLIP;
                else if (!hi_ber) nxt = ST_LOCK;
      ST_SLIP:  if (slip_done) nxt = ST_HUNT;
      default:  nxt = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_HUNT;
      slip_req <= 1'b0;
    end else begin
      st_q     <= nxt;
      slip_req <= (nxt == ST_SLIP) && (st_q != ST_SLIP);
    end
  end

  assign clr = (st_q == ST_SLIP);

  AST_SLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_req |=> !slip_req); // R8
  AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLIP && !slip_done) |=> (st_q == ST_SLIP)); // R8
  AST_SLIP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLIP && slip_done) |=> (st_q == ST_HUNT)); // R8
  AST_UNLOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SLIP && unlock_hit) |=> (st_q == ST_SLIP)); // R6
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import lock_pkg::*;
#(
  parameter int LOCK_RUN    = 64,
  parameter int WIN_FRAMES  = 64,
  parameter int UNLOCK_BAD  = 32,
  parameter int BER_WIN_CYC = 256,
  parameter int BER_BAD     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_vld,
  input  logic [1:0] frm_hdr,
  input  logic       slip_done,
  output logic       slip_req,
  output logic       sync_done,
  output logic [1:0] lock_state
);
  logic      good, lock_hit, unlock_hit, hi_ber, clr;
  lk_state_e st;

  assign good = hdr_good(frm_hdr);

  hdr_window #(
    .LOCK_RUN  (LOCK_RUN),
    .WIN_FRAMES(WIN_FRAMES),
    .UNLOCK_BAD(UNLOCK_BAD)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .fv        (frm_vld),
    .good      (good),
    .lock_hit  (lock_hit),
    .unlock_hit(unlock_hit)
  );

  ber_monitor #(
    .WIN_CYC(BER_WIN_CYC),
    .BAD_TH (BER_BAD)
  ) u_ber (
    .clk   (clk),
    .rst_n (rst_n),
    .fv    (frm_vld),
    .good  (good),
    .hi_ber(hi_ber)
  );

  lock_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_hit  (lock_hit),
    .unlock_hit(unlock_hit),
    .hi_ber    (hi_ber),
    .slip_done (slip_done),
    .st_q      (st),
    .slip_req  (slip_req),
    .clr       (clr)
  );

  assign sync_done  = (st == ST_LOCK);
  assign lock_state = st;

  AST_NOISY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NOISY) |-> (!slip_req && !sync_done)); // R7
  AST_LOCK_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT && !lock_hit) |=> (st != ST_LOCK)); // R3
endmodule

// File: tb/blk_lock_ctrl_tb.sv
module blk_lock_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_vld = 1'b0;
  logic [1:0] frm_hdr = 2'b01;
  logic       slip_done = 1'b0;
  logic       slip_req, sync_done;
  logic [1:0] lock_state;

  int n_chk = 0;
  int n_bad = 0;
  int ecnt = 0;
  int fcnt = 0;
  logic [1:0] expq[$];
  logic [1:0] prev_st = 2'd0;
  logic       mon_on = 1'b0;

  localparam int W = 256;

  blk_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_hdr(frm_hdr),
    .slip_done(slip_done), .slip_req(slip_req), .sync_done(sync_done),
    .lock_state(lock_state)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic chk(input bit c, input string req, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge: drive one frame, return at the next negedge
  task automatic send(input logic [1:0] h);
    frm_vld = 1'b1;
    frm_hdr = h;
    fcnt++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    frm_vld = 1'b0;
    frm_hdr = 2'b00;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] bad_h(input int i);
    return (i % 2) ? 2'b11 : 2'b00;
  endfunction

  function automatic logic [1:0] ok_h(input int i);
    return (i % 2) ? 2'b10 : 2'b01;
  endfunction

  // monitor: scoreboard of state changes
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (lock_state != prev_st) begin
        if (expq.size() == 0) chk(1'b0, "R6 unexpected transition", lock_state, prev_st);
        else begin
          logic [1:0] e;
          e = expq.pop_front();
          chk(lock_state == e, "R6 state order", lock_state, e);
        end
        chk(sync_done == (lock_state == 2'd1), "R9 sync_done", sync_done, lock_state == 2'd1);
        chk(slip_req == (lock_state == 2'd3), "R8 slip pulse on entry", slip_req, lock_state == 2'd3);
      end else if (slip_req) begin
        chk(1'b0, "R8 slip_req outside entry", 1, 0);
      end
      prev_st = lock_state;
    end
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lock_state == 2'd0 && !slip_req && !sync_done, "R2 in reset", lock_state, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk(lock_state == 2'd0 && !sync_done, "R2 after reset", lock_state, 0);
    idle(0);
    // edge count so far is 1; restart bench edge count to align with design windows
    rst_n = 1'b0; mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; ecnt = 0; mon_on = 1'b1; prev_st = 2'd0;

    // lock and high error rate in the same window (R3, R5, R6)
    for (int i = 0; i < 20; i++) send(bad_h(i));
    for (int i = 0; i < 63; i++) send(ok_h(i));
    chk(lock_state == 2'd0, "R3 63 good frames not enough", lock_state, 0);
    expq.push_back(2'd1);
    expq.push_back(2'd2);
    send(2'b10);
    chk(lock_state == 2'd1 && sync_done, "R3 lock on 64th good frame", lock_state, 1);
    idle(1);
    chk(lock_state == 2'd2 && !sync_done, "R7 noisy drops sync_done", lock_state, 2);
    expq.push_back(2'd1);
    for (int k = 0; k < 1200; k++) begin
      if (lock_state == 2'd1) break;
      send(ok_h(k));
    end
    chk(lock_state == 2'd1, "R6 return to locked", lock_state, 1);
    chk(ecnt == 2 * W + 1, "R5 flag clears at window end", ecnt, 2 * W + 1);

    // unlock from noisy, window aligned (R4, R8)
    while (ecnt % W != 0) idle(1);
    while (fcnt % 64 != 0) send(2'b01);
    expq.push_back(2'd2);
    expq.push_back(2'd3);
    for (int i = 0; i < 31; i++) send(bad_h(i));
    chk(lock_state == 2'd2, "R4 31 bad frames not enough", lock_state, 2);
    send(2'b00);
    chk(lock_state == 2'd3 && slip_req, "R4 slip on 32nd bad frame", lock_state, 3);
    idle(1);
    chk(!slip_req, "R8 slip request is one cycle", slip_req, 0);

    // slipping holds until slip_done (R8)
    for (int i = 0; i < 3; i++) send(2'b01);
    idle(3);
    chk(lock_state == 2'd3, "R8 hold in slipping", lock_state, 3);
    expq.push_back(2'd0);
    slip_done = 1'b1;
    idle(1);
    slip_done = 1'b0;
    fcnt = 0;
    chk(lock_state == 2'd0, "R8 slip_done to hunt", lock_state, 0);

    // unlock while hunting (R4)
    for (int i = 0; i < 31; i++) send(bad_h(i + 1));
    chk(lock_state == 2'd0, "R4 hunt 31 bad frames", lock_state, 0);
    expq.push_back(2'd3);
    send(2'b11);
    chk(lock_state == 2'd3, "R4 hunt slips on 32nd bad", lock_state, 3);
    expq.push_back(2'd0);
    slip_done = 1'b1;
    idle(1);
    slip_done = 1'b0;
    fcnt = 0;

    // clean relock, then ignored bad headers without strobe (R1, R3)
    idle(600);
    expq.push_back(2'd1);
    for (int i = 0; i < 64; i++) send(ok_h(i));
    chk(lock_state == 2'd1, "R3 relock after 64 good", lock_state, 1);
    idle(5);
    chk(lock_state == 2'd1, "R6 stays locked with flag low", lock_state, 1);
    idle(100);
    chk(lock_state == 2'd1 && sync_done, "R1 bad header without strobe ignored", lock_state, 1);

    chk(expq.size() == 0, "R6 all transitions seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule